// File: doc/BRIEF.md
# Gated Seven-Decade Frequency Counter with Scanned Display

The block counts the rising edges of a conditioned input signal in a chain of seven binary-coded-decimal decades, but only while a gate level is high. The gate width sets the resolution: a 1 s gate gives one count per hertz, and a 0.1 s gate gives one count per ten hertz. A separate update strobe copies the running count into a bank of display registers. A separate clear strobe zeroes the decades. Because of this double buffering, the shown value stays steady while the next gate interval is being accumulated.

The held digits are scanned onto a seven-segment display one digit at a time. Each rising edge of a slow external scan square wave, typically around 1.6 kHz, moves the scan to the next digit. Leading zeros are blanked, and an overflow indication travels with each update. The count input and the scan wave are asynchronous and are synchronised inside the block. The gate, update and clear inputs are plain levels or strobes that are synchronous to `clk`.

No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status line.

Top module: `dcc_top`

## Requirements
- R1: Each rising edge of `count_in` is counted exactly once, provided it stays high and low for at least two `clk` cycles each. The count is held as seven decades, each in the range 0..9, with carries rippling into the next decade. Decade 0 is the least significant.
- R2: Edges of `count_in` that are seen while `gate_in` is low leave the count unchanged.
- R3: A one-cycle `update_stb` copies the present count into the display registers. Counting that happens afterwards does not change the display until the next update.
- R4: `clear_stb` zeroes every decade and the running overflow flag. It does not touch the display registers. When clear and a count fall in the same cycle, clear takes priority.
- R5: When `update_stb` and `clear_stb` are high in the same cycle, the display receives the count as it was before the clear.
- R6: An increment from the all-nines count wraps the decades to zero and sets a running overflow flag. That flag stays set until a clear. `ovf_out` takes the flag's value on each update.
- R7: `digit_sel` is one-hot, and bit k selects decade k. After reset bit 0 is selected. Each rising edge of `scan_clk` advances the selection by one, and it wraps from the top digit back to bit 0.
- R8: `seg_out` bits {6..0} = {g,f,e,d,c,b,a}, active high. The codes are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. A blanked digit is 00.
- R9: Digit k>0 is blanked when the displayed digits k and above are all zero. Digit 0 is never blanked.
- R10: After reset, the count and display are zero, `digit_sel`=0000001, `seg_out`=3F and `ovf_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 1 | Asynchronous conditioned signal to be counted |
| gate_in | input | 1 | Counting enable level, synchronous |
| update_stb | input | 1 | Copy count to display registers, synchronous strobe |
| clear_stb | input | 1 | Zero the decades and the overflow flag, synchronous strobe |
| scan_clk | input | 1 | Asynchronous display scan square wave |
| digit_sel | output | NUM_DIGITS | One-hot digit select |
| seg_out | output | 7 | Segment pattern of the selected digit |
| ovf_out | output | 1 | Overflow flag held with the displayed value |

## Verification
The hardest case to reach from the ports is the overflow wrap. Seven decades need ten million input edges before they wrap, which is far too many for a short run. The bench therefore adds a second instance elaborated with two decades, so that a few hundred pulses carry it through 99 to 00 and raise the flag. The simultaneous update and clear, and the blanking of every digit position, are directed cases. These sit alongside random bursts of counted pulses and of ignored pulses, with random pulse widths.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  localparam seg_t SEG_BLANK = 7'h00;

  // {g,f,e,d,c,b,a}, active high
  function automatic seg_t bcd_to_seg(input bcd_t d);
    case (d)
      4'd0: bcd_to_seg = 7'h3F;
      4'd1: bcd_to_seg = 7'h06;
      4'd2: bcd_to_seg = 7'h5B;
      4'd3: bcd_to_seg = 7'h4F;
      4'd4: bcd_to_seg = 7'h66;
      4'd5: bcd_to_seg = 7'h6D;
      4'd6: bcd_to_seg = 7'h7D;
      4'd7: bcd_to_seg = 7'h07;
      4'd8: bcd_to_seg = 7'h7F;
      4'd9: bcd_to_seg = 7'h6F;
      default: bcd_to_seg = SEG_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/dcc_edge_sync.sv
`timescale 1ns/1ps
module dcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // newest synchronised sample high, previous low
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dcc_decade_chain.sv
`timescale 1ns/1ps
module dcc_decade_chain #(
  parameter int NUM_DIGITS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc_i,
  input  logic                       clear_i,
  output logic [NUM_DIGITS-1:0][3:0] digits_o,
  output logic                       wrap_o
);
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    logic [3:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clear_i)  q <= '0;
      else if (carry[g]) q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
    end
    assign carry[g+1] = carry[g] & (q == 4'd9);
    assign digits_o[g] = q;

    a_r1_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
      q <= 4'd9);
  end

  assign wrap_o = carry[NUM_DIGITS];

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (digits_o == '0));
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clear_i) |=> $stable(digits_o));
endmodule

// File: rtl/dcc_scan.sv
`timescale 1ns/1ps
module dcc_scan
  import dcc_pkg::*;
#(
  parameter int NUM_DIGITS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_i,
  input  logic [NUM_DIGITS-1:0][3:0] shown_i,
  output logic [NUM_DIGITS-1:0]      digit_sel_o,
  output logic [6:0]                 seg_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [IDX_W-1:0]      idx_q;
  logic [NUM_DIGITS-1:0] upper_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  // upper_zero[k]: digits k..top are all zero
  assign upper_zero[NUM_DIGITS-1] = (shown_i[NUM_DIGITS-1] == 4'd0);
  for (genvar k = NUM_DIGITS - 2; k >= 0; k--) begin : g_blank
    assign upper_zero[k] = upper_zero[k+1] & (shown_i[k] == 4'd0);
  end

  always_comb begin
    digit_sel_o = '0;
    digit_sel_o[idx_q] = 1'b1;
    if (idx_q != '0 && upper_zero[idx_q]) seg_o = SEG_BLANK;
    else                                  seg_o = bcd_to_seg(shown_i[idx_q]);
  end

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(digit_sel_o) == 1);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(digit_sel_o));
  a_r9_lsd_lit: assert property (@(posedge clk) disable iff (!rst_n)
    digit_sel_o[0] |-> (seg_o != SEG_BLANK));
endmodule

// File: rtl/dcc_top.sv
`timescale 1ns/1ps
module dcc_top #(
  parameter int NUM_DIGITS  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_in,
  input  logic                  gate_in,
  input  logic                  update_stb,
  input  logic                  clear_stb,
  input  logic                  scan_clk,
  output logic [NUM_DIGITS-1:0] digit_sel,
  output logic [6:0]            seg_out,
  output logic                  ovf_out
);
  logic cnt_rise, scan_rise, wrap;
  logic run_ovf_q;
  logic [NUM_DIGITS-1:0][3:0] run_digits;
  logic [NUM_DIGITS-1:0][3:0] shown_q;

  dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .async_i(count_in), .rise_o(cnt_rise));

  dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_scan_sync (
    .clk(clk), .rst_n(rst_n), .async_i(scan_clk), .rise_o(scan_rise));

  dcc_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk(clk), .rst_n(rst_n), .inc_i(cnt_rise & gate_in), .clear_i(clear_stb),
    .digits_o(run_digits), .wrap_o(wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_ovf_q <= 1'b0;
    else if (clear_stb) run_ovf_q <= 1'b0;
    else if (wrap)      run_ovf_q <= 1'b1;
  end

  // update captures pre-clear count even when clear is in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q <= '0;
      ovf_out <= 1'b0;
    end else if (update_stb) begin
      shown_q <= run_digits;
      ovf_out <= run_ovf_q;
    end
  end

  dcc_scan #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
    .clk(clk), .rst_n(rst_n), .step_i(scan_rise), .shown_i(shown_q),
    .digit_sel_o(digit_sel), .seg_o(seg_out));

  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_in && !clear_stb) |=> $stable(run_digits));
  a_r3_display_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !update_stb |=> ($stable(shown_q) && $stable(ovf_out)));
  a_r6_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_out) |-> $past(update_stb));
endmodule

// File: tb/dcc_top_tb.sv
`timescale 1ns/1ps
module dcc_top_tb_top;
  localparam int ND = 7;
  localparam int SND = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_in = 0, gate_in = 0, update_stb = 0, clear_stb = 0;
  logic scan_clk = 0, s_scan_clk = 0;
  logic [ND-1:0]  digit_sel;
  logic [6:0]     seg_out;
  logic           ovf_out;
  logic [SND-1:0] s_digit_sel;
  logic [6:0]     s_seg_out;
  logic           s_ovf_out;

  int total = 0, failed = 0, cycles = 0;
  int m_idx = 0, s_idx = 0;
  longint expect_val = 0;

  always #2 clk = ~clk;

  dcc_top #(.NUM_DIGITS(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .gate_in(gate_in),
    .update_stb(update_stb), .clear_stb(clear_stb), .scan_clk(scan_clk),
    .digit_sel(digit_sel), .seg_out(seg_out), .ovf_out(ovf_out));

  dcc_top #(.NUM_DIGITS(SND)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .gate_in(gate_in),
    .update_stb(update_stb), .clear_stb(clear_stb), .scan_clk(s_scan_clk),
    .digit_sel(s_digit_sel), .seg_out(s_seg_out), .ovf_out(s_ovf_out));

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input longint v, input int k);
    longint p = 1;
    for (int i = 0; i < k; i++) p = p * 10;
    if (k > 0 && (v / p) == 0) return 7'h00;
    return seg_of(int'((v / p) % 10));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_cnt(input int hi, input int lo);
    @(negedge clk) count_in = 1;
    repeat (hi) @(negedge clk);
    count_in = 0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) pulse_cnt($urandom_range(2, 4), $urandom_range(2, 4));
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input logic u, input logic c);
    @(negedge clk);
    update_stb = u; clear_stb = c;
    @(negedge clk);
    update_stb = 0; clear_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic step_main();
    @(negedge clk) scan_clk = 1;
    repeat (3) @(negedge clk);
    scan_clk = 0;
    repeat (3) @(negedge clk);
    m_idx = (m_idx + 1) % ND;
  endtask

  task automatic step_small();
    @(negedge clk) s_scan_clk = 1;
    repeat (3) @(negedge clk);
    s_scan_clk = 0;
    repeat (3) @(negedge clk);
    s_idx = (s_idx + 1) % SND;
  endtask

  // R7 R8 R9: full scan of the main display
  task automatic read_main(input longint v, input string req);
    for (int k = 0; k < ND; k++) begin
      chk({req, "/R7 sel"}, digit_sel, longint'(1) << m_idx);
      chk({req, "/R8/R9 seg"}, seg_out, exp_seg(v, m_idx));
      step_main();
    end
  endtask

  task automatic read_small(input longint v, input string req);
    for (int k = 0; k < SND; k++) begin
      chk({req, "/R7 sel"}, s_digit_sel, longint'(1) << s_idx);
      chk({req, "/R8/R9 seg"}, s_seg_out, exp_seg(v, s_idx));
      step_small();
    end
  endtask

  initial begin
    int n;
    int ign;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R10 reset state
    chk("R10 sel", digit_sel, 1);
    chk("R10 seg", seg_out, 7'h3F);
    chk("R10 ovf", ovf_out, 0);
    read_main(0, "R10");

    // R1 R2 R3: random bursts, accumulated across gates; pulses with gate low ignored
    for (int t = 0; t < 5; t++) begin
      strobe(0, 1);
      expect_val = 0;
      n = $urandom_range(0, 1200);
      ign = $urandom_range(0, 20);
      gate_in = 0; burst(ign);
      gate_in = 1; burst(n);
      gate_in = 0; burst(ign);
      expect_val = n;
      strobe(1, 0);
      read_main(expect_val, "R1/R2 random");
      chk("R6 no ovf", ovf_out, 0);
    end

    // R1 carry ripple through several decades
    strobe(0, 1);
    gate_in = 1; burst(1000); gate_in = 0;
    strobe(1, 0);
    read_main(1000, "R1 carry");

    // R3 display stable while counting continues, then shows accumulated total
    gate_in = 1; burst(57); gate_in = 0;
    read_main(1000, "R3 hold");
    strobe(1, 0);
    read_main(1057, "R3 update");

    // R4 clear leaves display alone
    strobe(0, 1);
    read_main(1057, "R4 display kept");
    strobe(1, 0);
    read_main(0, "R4 cleared");

    // R5 update and clear together
    gate_in = 1; burst(37); gate_in = 0;
    strobe(1, 1);
    read_main(37, "R5 pre-clear");
    strobe(1, 0);
    read_main(0, "R5 cleared");

    // R6 overflow on the two-decade instance
    strobe(0, 1);
    gate_in = 1; burst(100); gate_in = 0;
    strobe(1, 0);
    chk("R6 ovf set", s_ovf_out, 1);
    chk("R6 main no ovf", ovf_out, 0);
    read_small(0, "R6 wrap");
    read_main(100, "R6 main");
    gate_in = 1; burst(5); gate_in = 0;
    strobe(1, 0);
    chk("R6 ovf sticky", s_ovf_out, 1);
    read_small(5, "R6 after wrap");
    strobe(0, 1);
    chk("R6 ovf held until update", s_ovf_out, 1);
    strobe(1, 0);
    chk("R6 ovf cleared", s_ovf_out, 0);

    // R9 blanking at every digit position
    strobe(0, 1);
    gate_in = 1; burst(205); gate_in = 0;
    strobe(1, 0);
    read_main(205, "R9 inner zero");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; failed++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule